// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block lets an external master on a two-wire serial bus read and write a small file of 8-bit registers. A system clock samples SCL and SDA through synchronizers, well above the bus rate. The block finds bus start, repeated start and stop events. It compares the 7-bit device address with a strapped value. It then moves data bytes between the bus and a simple register-file port. SDA is open-drain: the block only ever pulls the line low through an output enable.

A write carries a word-address byte that loads an internal pointer, followed by any number of data bytes. Each data byte is written at the pointer, and the pointer then steps by one. A read first sets the pointer with a write phase. A repeated start then turns the bus around, and the slave sends bytes from the pointer for as long as the master acknowledges them. The pointer keeps its value across starts and stops. A later read with no new word address therefore continues where the last transfer ended.

Top module: `twi_regport`

## Requirements
- R1: After reset the slave releases SDA (`sda_oe` = 0) and does not write (`reg_wr` = 0).
- R2: A stop (SDA rising while SCL is high) sends the slave to idle with SDA released. A start (SDA falling while SCL is high) releases SDA and begins a new address byte.
- R3: The first byte after a start is the device address, MSB first, with the read/write flag in bit 0 (0 = write, 1 = read). When bits 7..1 equal `slv_addr`, the slave holds SDA low through the ninth SCL pulse as an acknowledge.
- R4: When the device address does not match, the slave leaves SDA released. Until the next start it acknowledges nothing and writes nothing.
- R5: In a write, the first byte after the address loads the pointer and is acknowledged. Each later byte is acknowledged and written once at the pointer (`reg_wr` for one clock, with `reg_addr` = pointer and `reg_wdata` = the byte). The pointer then steps by one.
- R6: The pointer is 8 bits wide and steps from 0xFF to 0x00.
- R7: After a repeated start with flag 1, the slave sends the register at the pointer MSB first and steps the pointer after each byte. It continues while the master acknowledges and releases SDA after a master not-acknowledge.
- R8: The slave changes `sda_oe` only while SCL is low. The one exception is a release caused by a start or stop.
- R9: A start or stop in the middle of a byte abandons that byte and writes nothing.
- R10: The pointer is kept across repeated starts and stops, so a read with no word-address phase continues from the last position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| slv_addr | input | 7 | Strapped device address |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr | output | 1 | One-clock write strobe to the register file |
| reg_addr | output | PTR_W (8) | Register pointer, used for reads and writes |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
Multi-byte writes and reads check the data path and pointer stepping. Every write is a distinct byte, so a byte in the wrong slot or a missing increment shows up as a data mismatch. A run across 0xFF separates correct wrapping from an overflowing pointer. A foreign device address followed by normal-looking bytes separates a quiet slave from one that decodes anyway. Transfers cut off by a stop or start partway through a byte separate true aborts from partial writes. A read with no word-address phase separates a kept pointer from one that is reset.

// File: rtl/twi_pkg.sv
package twi_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RXB,
    ST_WACK,
    ST_TXB,
    ST_MACK,
    ST_SKIP
  } twi_state_e;

  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] b, input logic bit_in);
    return {b[BYTE_W-2:0], bit_in};
  endfunction

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
    return (b[BYTE_W-1:1] == dev);
  endfunction

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] prev
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= '1;
        prev[g] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], din[g]};
        prev[g] <= chain[STAGES-1];
      end
    end
    assign lvl[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/twi_ptr.sv
module twi_ptr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] ptr
);

  function automatic logic [W-1:0] ptr_next(input logic [W-1:0] p);
    return p + {{(W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr_next(ptr);
  end

endmodule

// File: rtl/twi_regport.sv
module twi_regport
  import twi_pkg::*;
#(
  parameter int PTR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [6:0]       slv_addr,
  output logic             sda_oe,
  output logic             reg_wr,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic [1:0] lvl, prv;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;

  twi_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din ({sda_i, scl_i}),
    .lvl (lvl),
    .prev (prv)
  );

  assign scl_lvl  = lvl[0];
  assign sda_lvl  = lvl[1];
  assign scl_rise = scl_lvl & ~prv[0];
  assign scl_fall = ~scl_lvl & prv[0];
  assign ev_start = scl_lvl & prv[0] & prv[1] & ~sda_lvl;
  assign ev_stop  = scl_lvl & prv[0] & ~prv[1] & sda_lvl;

  twi_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       rx_sh, tx_sh;
  logic             rw, have_ptr, mack, oe;
  logic             byte_full, wr_fire, ptr_load, rd_step, ptr_inc;
  logic [PTR_W-1:0] ptr;

  assign byte_full = (cnt == CNT_FULL);
  assign wr_fire   = scl_fall & byte_full & (state == ST_RXB) & have_ptr;
  assign ptr_load  = scl_fall & byte_full & (state == ST_RXB) & ~have_ptr;
  assign rd_step   = scl_fall & byte_full & (state == ST_TXB);
  assign ptr_inc   = wr_fire | rd_step;

  twi_ptr #(.W(PTR_W)) u_ptr (
    .clk (clk),
    .rst_n (rst_n),
    .load (ptr_load),
    .load_val (PTR_W'(rx_sh)),
    .step (ptr_inc),
    .ptr (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rw       <= 1'b0;
      have_ptr <= 1'b0;
      mack     <= 1'b0;
      oe       <= 1'b0;
    end else if (ev_start) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      oe       <= 1'b0;
      have_ptr <= 1'b0;
    end else if (ev_stop) begin
      state <= ST_IDLE;
      cnt   <= '0;
      oe    <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_sh <= shift_in(rx_sh, sda_lvl);
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && byte_full) begin
            cnt <= '0;
            if (addr_hit(rx_sh, slv_addr)) begin
              oe    <= 1'b1;
              rw    <= rx_sh[0];
              state <= ST_AACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx_sh <= reg_rdata;
              oe    <= ~reg_rdata[7];
              state <= ST_TXB;
            end else begin
              oe    <= 1'b0;
              state <= ST_RXB;
            end
          end
        end
        ST_RXB: begin
          if (scl_rise) begin
            rx_sh <= shift_in(rx_sh, sda_lvl);
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && byte_full) begin
            cnt      <= '0;
            oe       <= 1'b1;
            have_ptr <= 1'b1;
            state    <= ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe    <= 1'b0;
            state <= ST_RXB;
          end
        end
        ST_TXB: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (byte_full) begin
              oe    <= 1'b0;
              cnt   <= '0;
              state <= ST_MACK;
            end else if (cnt != '0) begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              oe    <= ~tx_sh[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack) begin
              tx_sh <= reg_rdata;
              oe    <= ~reg_rdata[7];
              state <= ST_TXB;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe    = oe;
  assign reg_wr    = wr_fire;
  assign reg_addr  = ptr;
  assign reg_wdata = rx_sh;

endmodule

// File: rtl/twi_regport_chk.sv
module twi_regport_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             reg_wr,
  input logic [PTR_W-1:0] reg_addr,
  input logic             scl_fall,
  input logic             ev_start,
  input logic             ev_stop,
  input logic             rd_step
);

  p_oe_moves_low_scl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || ev_start || ev_stop));

  p_wr_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_addr == PTR_W'($past(reg_addr) + 1'b1));

  p_wr_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_rd_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step |=> reg_addr == PTR_W'($past(reg_addr) + 1'b1));

  p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe);

  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!sda_oe && !reg_wr));

endmodule

bind twi_regport twi_regport_chk #(.PTR_W(PTR_W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .sda_oe (sda_oe),
  .reg_wr (reg_wr),
  .reg_addr (reg_addr),
  .scl_fall (scl_fall),
  .ev_start (ev_start),
  .ev_stop (ev_stop),
  .rd_step (rd_step)
);

// File: tb/twi_regport_test.sv
module twi_regport_test;

  localparam int Q = 5;
  localparam logic [6:0] DEV = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_oe = 1'b0;
  logic sda_oe, reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];

  typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
  wr_t wq[$];

  int total = 0;
  int bad = 0;
  int r8_viol = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sda = ~(m_oe | sda_oe);

  twi_regport uut (
    .clk (clk),
    .rst_n (rst_n),
    .scl_i (m_scl),
    .sda_i (sda),
    .slv_addr (DEV),
    .sda_oe (sda_oe),
    .reg_wr (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  // register file model behind the port
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every write strobe must match the next queued item
  always @(negedge clk) begin
    if (rst_n && reg_wr) begin
      if (wq.size() == 0) begin
        chk(0, "R4/R9 unexpected write", {reg_addr, reg_wdata}, 0);
      end else begin
        wr_t e;
        e = wq.pop_front();
        chk({reg_addr, reg_wdata} == {e.a, e.d}, "R5 write addr/data", {reg_addr, reg_wdata}, {e.a, e.d});
      end
    end
  end

  // R8 monitor: slave output changes only while SCL is low
  logic last_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != last_oe && m_scl) r8_viol++;
    last_oe = sda_oe;
  end

  task automatic tick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_oe = 1'b0; tick();
    m_scl = 1'b1; tick();
    m_oe = 1'b1; tick();
    m_scl = 1'b0; tick();
  endtask

  task automatic bus_stop();
    m_oe = 1'b1; tick();
    m_scl = 1'b1; tick();
    m_oe = 1'b0; tick();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_oe = ~b[i]; tick();
      m_scl = 1'b1; tick();
      m_scl = 1'b0; tick();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_oe = 1'b0; tick();
    m_scl = 1'b1; tick();
    ack = (sda == 1'b0);
    m_scl = 1'b0; tick();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    m_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick();
      m_scl = 1'b1; tick();
      b[i] = sda;
      m_scl = 1'b0;
    end
    tick();
    m_oe = give_ack; tick();
    m_scl = 1'b1; tick();
    m_scl = 1'b0; tick();
    m_oe = 1'b0; tick();
  endtask

  // driver: write a run of bytes, queueing expected strobes
  task automatic drv_write(input logic [7:0] wa, input logic [7:0] d[]);
    bit ack;
    logic [7:0] p;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R3 address ack (write)", ack, 1);
    send_byte(wa, ack);          chk(ack, "R5 word address ack", ack, 1);
    p = wa;
    foreach (d[k]) begin
      wq.push_back({p, d[k]});
      exp_mem[p] = d[k];
      send_byte(d[k], ack);      chk(ack, "R5 data ack", ack, 1);
      p = p + 8'd1;
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
  endtask

  task automatic drv_read(input logic [7:0] wa, input int n);
    bit ack;
    logic [7:0] b, p;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R3 address ack", ack, 1);
    send_byte(wa, ack);          chk(ack, "R5 pointer ack", ack, 1);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R3 read address ack", ack, 1);
    p = wa;
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k != n - 1);
      chk(b == exp_mem[p], "R7/R6 read data", b, exp_mem[p]);
      p = p + 8'd1;
    end
    chk(sda_oe == 1'b0, "R7 release after nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0 && reg_wr == 1'b0, "R1 reset state", {sda_oe, reg_wr}, 0);
    rst_n = 1'b1;
    tick();

    drv_write(8'h10, '{8'hA5, 8'h3C, 8'hF0, 8'h77});
    drv_read(8'h10, 3);

    // R10: read with no word address continues at 0x13
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R10 address ack", ack, 1);
    recv_byte(b, 1'b0);
    chk(b == 8'h77, "R10 pointer kept", b, 8'h77);
    bus_stop();

    // R6: wrap
    drv_write(8'hFE, '{8'h11, 8'h22, 8'h33});
    drv_read(8'hFF, 2);

    // R4: foreign address
    bus_start();
    send_byte({7'h2A, 1'b0}, ack); chk(!ack, "R4 no ack on mismatch", ack, 0);
    send_byte(8'h10, ack);         chk(!ack, "R4 ignored word address", ack, 0);
    send_byte(8'h99, ack);         chk(!ack, "R4 ignored data", ack, 0);
    bus_stop();

    // R9: stop partway through a data byte
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h10, ack);
    send_bits(8'hEE, 4);
    m_oe = 1'b0; tick();
    bus_stop();
    // R9: start partway through, then read at 0x11
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h11, ack);
    send_bits(8'h5A, 3);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R9 read after abort ack", ack, 1);
    recv_byte(b, 1'b0);
    chk(b == 8'h3C, "R9 partial byte not written", b, 8'h3C);
    bus_stop();
    drv_read(8'h10, 1);

    tick();
    chk(wq.size() == 0, "R5 all expected writes seen", wq.size(), 0);
    chk(r8_viol == 0, "R8 sda changes only with SCL low", r8_viol, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule